// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Output Timing

This block buffers data words between two unrelated clock domains. A producer stores a word on each write-clock edge where its enable is high, and a consumer takes words out on read-clock edges. Neither clock is constrained relative to the other. Both pointers cross domains as Gray codes through two-flop synchronisers. Full is judged on the write side and empty on the read side. Each side judges from a possibly stale copy of the other pointer, so both flags err toward safety.

Two output personalities share one core, and the choice is latched while master reset is held. In standard timing, the read flag reports "empty" and a word only reaches the output register when a read is requested. In fall-through timing, the read flag reports "a word is on the output", the write flag reports "space available", and the head word moves to the output without being asked for.

The block also provides:
- a half-full flag;
- almost-empty and almost-full flags, with thresholds fed from an external offset block;
- a partial reset that empties the buffer but keeps the latched mode;
- a retransmit pulse that rewinds reading to the first word stored since the last reset;
- an output enable that floats the data outputs.

Top module: `dcf_fifo`

## Requirements
- R1: While either reset is low, and after it is released, the pointers are zero. In standard mode, rd_flag=1 and wr_flag=0. In fall-through mode, rd_flag=0 and wr_flag=1. Also half_full=0, almost_empty=1, almost_full=0 and the output register holds 0.
- R2: A word is stored at each rising wclk edge with wr_en=1, and the buffer is not full. Words leave in the order they were stored.
- R3: In standard mode (mode_sel=0 at master reset), rd_flag=1 means no word can be read. A stored word reaches q only at a rising rclk edge with rd_en=1.
- R4: In fall-through mode (mode_sel=1 at master reset), rd_flag=1 means a valid word is on q, and wr_flag=1 means a write will be accepted. The head word appears on q without rd_en. The word holds until a read edge, which replaces it with the next word or clears rd_flag.
- R5: After a write into an empty buffer, rd_flag falls on the 2nd rising rclk edge in standard mode. In fall-through mode, the word is on q with rd_flag=1 on the 3rd rising rclk edge.
- R6: With DEPTH words held, wr_flag=1 in standard mode. A further write changes nothing: the stored contents and the read order are unchanged.
- R7: In standard mode, a read while empty leaves q and the read pointer unchanged.
- R8: half_full=1 when the write-side occupancy is at least DEPTH/2.
- R9: almost_empty=1 when the read-side occupancy is at most ae_gap. almost_full=1 when DEPTH minus the write-side occupancy is at most af_gap.
- R10: A rising rclk edge with rt=1 returns reading to the first word stored since the last reset. This is valid while fewer than DEPTH words have been written since that reset.
- R11: When oe=0, every bit of q is high impedance.
- R12: mode_sel is sampled only while mrst_n=0. Changing it at any other time has no effect on the flags.
- R13: A partial reset (prst_n=0) empties the buffer and keeps the latched mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, synchronous in each domain |
| prst_n | input | 1 | Partial reset, active low, keeps the latched mode |
| mode_sel | input | 1 | 0 = standard timing, 1 = fall-through; sampled during master reset |
| din | input | DW | Write data |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| rt | input | 1 | Retransmit: rewind reading to the first stored word |
| oe | input | 1 | Output enable; 0 floats q |
| ae_gap | input | AW+1 | Almost-empty threshold |
| af_gap | input | AW+1 | Almost-full threshold |
| q | output | DW | Registered read data, three-state |
| rd_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| wr_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| half_full | output | 1 | Occupancy at least DEPTH/2 |
| almost_empty | output | 1 | Read-side occupancy at most ae_gap |
| almost_full | output | 1 | Free space at most af_gap |

## Verification
The main path is exercised with several fill patterns, each aimed at a different fault:
- A single word into an empty buffer measures the crossing latency and shows whether data leaks out before a read.
- A ten-word burst walks the half-full and almost-empty edges, and shows whether ordering is kept.
- A fill to capacity with one extra write separates a dropped overflow from a corrupted slot.
- A read on empty tells an ignored read apart from a pointer that slips.

The same single-word fill, repeated after the mode and partial-reset sequences, shows whether the flag meanings follow the latched mode rather than the pin.

// File: rtl/dcf_pkg.sv
// Shared types for the dual-clock FIFO.
package dcf_pkg;

    // Output timing personality latched at master reset.
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } dcf_mode_e;

endpackage

// File: rtl/dcf_gray_sync.sv
// Two-flop synchroniser for a Gray-coded pointer, with binary conversion.
// Assumes the source changes at most one bit per source clock edge.
module dcf_gray_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Capture the foreign pointer through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    // Gray to binary: each bit is the parity of all bits at or above it.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            bin_out[i] = ^(stage2 >> i);
        end
    end
endmodule

// File: rtl/dcf_wr_side.sv
// Write-domain control: write pointer, full/input-ready, half-full, almost-full.
// Assumes resets are held for several wclk edges.
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic        clk,
    input  logic        mrst_n,
    input  logic        prst_n,
    input  logic        mode_sel,
    input  logic        wr_en,
    input  logic [AW:0] rd_gray,
    input  logic [AW:0] af_gap,
    output logic [AW:0] wptr,
    output logic [AW:0] wgray,
    output logic        mem_we,
    output logic        wr_flag,
    output logic        half_full,
    output logic        almost_full
);
    localparam int          PW     = AW + 1;
    localparam logic [AW:0] DEPTH_P = PW'(1) << AW;
    localparam logic [AW:0] HALF_P  = DEPTH_P >> 1;

    logic        rst_n;
    logic [AW:0] rptr_seen;
    logic [AW:0] occ;
    logic [AW:0] wptr_nxt;
    logic        full;
    dcf_mode_e   mode_q;

    assign rst_n = mrst_n & prst_n;

    dcf_gray_sync #(.W(PW)) u_rsync (
        .clk     (clk),
        .rst_n   (rst_n),
        .gray_in (rd_gray),
        .bin_out (rptr_seen)
    );

    // Latch the timing personality only during master reset.
    always_ff @(posedge clk) begin
        if (!mrst_n) mode_q <= dcf_mode_e'(mode_sel);
    end

    assign occ      = wptr - rptr_seen;
    assign full     = (occ == DEPTH_P);
    assign mem_we   = wr_en && !full;
    assign wptr_nxt = wptr + PW'(1);

    // Advance the binary and Gray write pointers on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            wgray <= '0;
        end else if (mem_we) begin
            wptr  <= wptr_nxt;
            wgray <= wptr_nxt ^ (wptr_nxt >> 1);
        end
    end

    assign wr_flag     = (mode_q == MODE_FWFT) ? !full : full;
    assign half_full   = (occ >= HALF_P);
    assign almost_full = ((DEPTH_P - occ) <= af_gap);

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> $stable(wptr));

    a_r8_full_is_half: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> half_full);

    a_r2_gray_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(wgray ^ $past(wgray)) <= 1));

    a_r12_mode_hold: assert property (@(posedge clk) disable iff (!mrst_n)
        1'b1 |=> $stable(mode_q));
endmodule

// File: rtl/dcf_rd_side.sv
// Read-domain control: read pointer, output register, empty/output-ready,
// almost-empty and retransmit. Memory data arrives combinationally at rptr.
// Assumes resets are held for several rclk edges.
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          mode_sel,
    input  logic          rd_en,
    input  logic          rt,
    input  logic [AW:0]   wr_gray,
    input  logic [AW:0]   ae_gap,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW:0]   rptr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] q_reg,
    output logic          rd_flag,
    output logic          almost_empty
);
    localparam int PW = AW + 1;

    logic        rst_n;
    logic [AW:0] wptr_seen;
    logic [AW:0] occ;
    logic [AW:0] rptr_nxt;
    logic        mem_empty;
    logic        q_valid;
    logic        pop;
    dcf_mode_e   mode_q;

    assign rst_n = mrst_n & prst_n;

    dcf_gray_sync #(.W(PW)) u_wsync (
        .clk     (clk),
        .rst_n   (rst_n),
        .gray_in (wr_gray),
        .bin_out (wptr_seen)
    );

    // Latch the timing personality only during master reset.
    always_ff @(posedge clk) begin
        if (!mrst_n) mode_q <= dcf_mode_e'(mode_sel);
    end

    assign occ       = wptr_seen - rptr;
    assign mem_empty = (occ == '0);
    assign rptr_nxt  = rptr + PW'(1);

    // Standard mode pops on request; fall-through refills an empty output.
    always_comb begin
        if (mode_q == MODE_FWFT) pop = !mem_empty && (!q_valid || rd_en);
        else                     pop = !mem_empty && rd_en;
    end

    // Pointer, output register and valid bit; retransmit rewinds to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr    <= '0;
            rgray   <= '0;
            q_reg   <= '0;
            q_valid <= 1'b0;
        end else if (rt) begin
            rptr    <= '0;
            rgray   <= '0;
            q_valid <= 1'b0;
        end else if (pop) begin
            rptr    <= rptr_nxt;
            rgray   <= rptr_nxt ^ (rptr_nxt >> 1);
            q_reg   <= mem_rdata;
            q_valid <= 1'b1;
        end else if (rd_en) begin
            q_valid <= 1'b0;
        end
    end

    assign rd_flag      = (mode_q == MODE_FWFT) ? q_valid : mem_empty;
    assign almost_empty = (occ <= ae_gap);

    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STD && rd_en && mem_empty && !rt) |=> $stable(rptr));

    a_r4_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_FWFT && q_valid && !rd_en && !rt)
            |=> (q_valid && $stable(q_reg)));

    a_r10_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        rt |=> (rptr == '0));
endmodule

// File: rtl/dcf_fifo.sv
// Dual-clock FIFO top: storage array plus write- and read-domain control.
// Assumes each reset is held long enough for both clocks to see it.
module dcf_fifo #(
    parameter int DW = 9,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          mode_sel,
    input  logic [DW-1:0] din,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          rt,
    input  logic          oe,
    input  logic [AW:0]   ae_gap,
    input  logic [AW:0]   af_gap,
    output logic [DW-1:0] q,
    output logic          rd_flag,
    output logic          wr_flag,
    output logic          half_full,
    output logic          almost_empty,
    output logic          almost_full
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW:0]   wptr;
    logic [AW:0]   wgray;
    logic [AW:0]   rptr;
    logic [AW:0]   rgray;
    logic          mem_we;
    logic [DW-1:0] q_reg;

    dcf_wr_side #(.AW(AW)) u_wr (
        .clk         (wclk),
        .mrst_n      (mrst_n),
        .prst_n      (prst_n),
        .mode_sel    (mode_sel),
        .wr_en       (wr_en),
        .rd_gray     (rgray),
        .af_gap      (af_gap),
        .wptr        (wptr),
        .wgray       (wgray),
        .mem_we      (mem_we),
        .wr_flag     (wr_flag),
        .half_full   (half_full),
        .almost_full (almost_full)
    );

    // Store accepted words at the write pointer.
    always_ff @(posedge wclk) begin
        if (mem_we) mem[wptr[AW-1:0]] <= din;
    end

    dcf_rd_side #(.AW(AW), .DW(DW)) u_rd (
        .clk          (rclk),
        .mrst_n       (mrst_n),
        .prst_n       (prst_n),
        .mode_sel     (mode_sel),
        .rd_en        (rd_en),
        .rt           (rt),
        .wr_gray      (wgray),
        .ae_gap       (ae_gap),
        .mem_rdata    (mem[rptr[AW-1:0]]),
        .rptr         (rptr),
        .rgray        (rgray),
        .q_reg        (q_reg),
        .rd_flag      (rd_flag),
        .almost_empty (almost_empty)
    );

    assign q = oe ? q_reg : {DW{1'bz}};
endmodule

// File: tb/test_dcf_fifo.sv
`timescale 1ns/10ps
module test_dcf_fifo;
    localparam int DW = 9;
    localparam int AW = 4;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          mrst_n = 1'b0;
    logic          prst_n = 1'b1;
    logic          mode_sel = 1'b0;
    logic [DW-1:0] din = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic          rt = 1'b0;
    logic          oe = 1'b1;
    logic [AW:0]   ae_gap = 5'd2;
    logic [AW:0]   af_gap = 5'd2;
    logic [DW-1:0] q;
    logic          rd_flag, wr_flag, half_full, almost_empty, almost_full;

    int n_chk = 0;
    int n_bad = 0;

    // Burst table: {expected half_full after this write, data}.
    localparam logic [DW:0] VEC [10] = '{
        {1'b0, 9'h101}, {1'b0, 9'h0F2}, {1'b0, 9'h033}, {1'b0, 9'h1C4},
        {1'b0, 9'h055}, {1'b0, 9'h0A6}, {1'b0, 9'h177}, {1'b1, 9'h008},
        {1'b1, 9'h199}, {1'b1, 9'h0EA}
    };

    dcf_fifo #(.DW(DW), .AW(AW)) i_dcf_fifo (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
        .mode_sel(mode_sel), .din(din), .wr_en(wr_en), .rd_en(rd_en),
        .rt(rt), .oe(oe), .ae_gap(ae_gap), .af_gap(af_gap), .q(q),
        .rd_flag(rd_flag), .wr_flag(wr_flag), .half_full(half_full),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    always #4 wclk = ~wclk;
    initial begin
        #1.25;
        forever #5.5 rclk = ~rclk;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [DW-1:0] d);
        @(negedge wclk);
        wr_en = 1'b1;
        din = d;
        @(posedge wclk);
        #0.5;
        wr_en = 1'b0;
    endtask

    task automatic take();
        @(negedge rclk);
        rd_en = 1'b1;
        @(posedge rclk);
        #0.5;
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(posedge wclk);
        repeat (4) @(posedge rclk);
        #0.5;
    endtask

    task automatic master_reset(input logic m);
        mrst_n = 1'b0;
        mode_sel = m;
        repeat (3) @(posedge wclk);
        repeat (3) @(posedge rclk);
        @(negedge wclk);
        mrst_n = 1'b1;
        settle();
    endtask

    // Count rclk edges until rd_flag reaches the wanted level.
    task automatic edges_until(input logic want, output int cnt);
        cnt = 0;
        while (rd_flag !== want && cnt < 10) begin
            @(posedge rclk);
            #0.5;
            cnt++;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int cnt;
        master_reset(1'b0);
        // R1 reset state, standard mode
        chk("R1 rd_flag", rd_flag, 1);
        chk("R1 wr_flag", wr_flag, 0);
        chk("R1 half_full", half_full, 0);
        chk("R1 almost_empty", almost_empty, 1);
        chk("R1 almost_full", almost_full, 0);
        chk("R1 q", q, 0);

        // R12 mode pin ignored outside master reset
        mode_sel = 1'b1;
        settle();
        chk("R12 wr_flag", wr_flag, 0);
        chk("R12 rd_flag", rd_flag, 1);
        mode_sel = 1'b0;

        // R5 / R3 latency and no leak before a read
        put(9'h15A);
        edges_until(1'b0, cnt);
        chk("R5 std latency", cnt, 2);
        chk("R3 no early data", q, 0);
        take();
        chk("R3 read data", q, 9'h15A);
        settle();

        // R7 read on empty ignored
        take();
        chk("R7 q unchanged", q, 9'h15A);
        chk("R7 still empty", rd_flag, 1);

        // R2 / R8 / R9 burst from the table
        for (int i = 0; i < 10; i++) begin
            put(VEC[i][DW-1:0]);
            chk("R8 half_full", half_full, VEC[i][DW]);
        end
        settle();
        chk("R9 not almost_empty", almost_empty, 0);
        for (int i = 0; i < 10; i++) begin
            take();
            chk("R2 order", q, VEC[i][DW-1:0]);
            chk("R9 almost_empty", almost_empty, (9 - i) <= 2);
        end
        settle();

        // R6 fill to capacity and overflow
        for (int i = 0; i < 16; i++) begin
            put(9'h040 + 9'(i));
            if (i == 12) chk("R9 almost_full off", almost_full, 0);
            if (i == 13) chk("R9 almost_full on", almost_full, 1);
            if (i == 14) chk("R6 not full", wr_flag, 0);
        end
        chk("R6 full", wr_flag, 1);
        put(9'h1FF);
        settle();
        for (int i = 0; i < 16; i++) begin
            take();
            chk("R6 contents", q, 9'h040 + 9'(i));
        end
        chk("R6 empty after drain", rd_flag, 1);

        // R11 output enable
        oe = 1'b0;
        #1;
        chk("R11 float", (q === {DW{1'bz}}), 1);
        oe = 1'b1;

        // R10 retransmit
        master_reset(1'b0);
        for (int i = 0; i < 5; i++) put(9'h020 + 9'(i));
        settle();
        take();
        take();
        chk("R10 before rewind", q, 9'h021);
        @(negedge rclk);
        rt = 1'b1;
        @(posedge rclk);
        #0.5;
        rt = 1'b0;
        take();
        chk("R10 first word again", q, 9'h020);
        take();
        chk("R10 second word again", q, 9'h021);

        // R4 / R1 fall-through mode
        master_reset(1'b1);
        chk("R1 fwft rd_flag", rd_flag, 0);
        chk("R1 fwft wr_flag", wr_flag, 1);
        put(9'h0AB);
        edges_until(1'b1, cnt);
        chk("R5 fwft latency", cnt, 3);
        chk("R4 word without read", q, 9'h0AB);
        put(9'h0CD);
        settle();
        chk("R4 head holds", q, 9'h0AB);
        take();
        chk("R4 next word", q, 9'h0CD);
        chk("R4 still ready", rd_flag, 1);
        take();
        chk("R4 drained", rd_flag, 0);

        // R13 partial reset keeps fall-through mode
        put(9'h011);
        put(9'h012);
        settle();
        mode_sel = 1'b0;
        prst_n = 1'b0;
        repeat (3) @(posedge wclk);
        repeat (3) @(posedge rclk);
        @(negedge wclk);
        prst_n = 1'b1;
        settle();
        chk("R13 emptied", rd_flag, 0);
        chk("R13 mode kept", wr_flag, 1);
        put(9'h133);
        settle();
        chk("R13 ready again", rd_flag, 1);
        chk("R13 data", q, 9'h133);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule